// File: doc/BRIEF.md
# Fifth-Order Fixed-Point IIR Lowpass Cascade

This block is a streaming lowpass filter of fifth order. It is built as three direct-form-I sections in series: two full second-order sections and a last section whose second-order terms are zero. Every section has its own numerator and feedback multiply-accumulate paths. The signal is put back into one common fixed-point section format between the stages.

A new signed 8-bit sample is accepted on every cycle that `in_valid` is high. Exactly one signed 9-bit result leaves, with `out_valid`, a fixed number of clock edges later. Samples may arrive back to back or with idle gaps of any length. The state does not move while no sample is present. Coefficients and per-section scale values are parameters. With scaling applied, every scale value is one.

The arithmetic follows fixed rules. Products keep full precision. Each product is rounded into an accumulator, and the numerator and feedback accumulators have different fraction lengths. Every narrowing rounds to nearest, with ties toward plus infinity, and wraps on overflow.

Top module: `iir_lp5_cascade`

## Requirements
- R1: The input (signed 8-bit, 7 fraction bits) is moved into the section format (signed 20-bit, 15 fraction bits) by a left shift of 8. At each section's entry the value is multiplied by that section's 16-bit scale value (14 fraction bits), rounded to nearest with ties upward, and wrapped to 20 bits.
- R2: Each numerator product (scaled input and the two previous scaled inputs, each times a 16-bit coefficient with 14 fraction bits) is formed at full precision, with 29 fraction bits. It is then rounded into a signed 32-bit accumulator with 24 fraction bits, and the sum wraps at 32 bits.
- R3: The numerator sum is moved one bit left into a signed 32-bit feedback accumulator with 25 fraction bits. The products a1·y[n−1] and a2·y[n−2] are each rounded from 29 to 25 fraction bits and subtracted, with wrap. The section output is this accumulator rounded to the section format with wrap. The leading feedback coefficient is one.
- R4: The filter output is the last section's value rounded from 15 to 7 fraction bits and wrapped to signed 9 bits.
- R5: `out_valid` rises exactly 4 rising edges (the section count plus one) after the edge that samples `in_valid` high. There is one output per accepted sample and no output strobe without one.
- R6: With `in_valid` low, no delay state and no output changes. `out_sample` holds its last value, so a stream with idle gaps gives the same output sequence as the same stream sent back to back.
- R7: A synchronous reset clears all delay states, `out_valid` and `out_sample` to zero. Reset takes precedence over a sample presented in the same cycle, and samples still in flight are discarded.
- R8: With the default coefficients, a constant input of 64 held for 700 samples gives an output within 3 LSBs of 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present on `in_sample` this cycle |
| in_sample | input | 8 | Signed input sample, 7 fraction bits |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_sample | output | 9 | Signed filtered sample, 7 fraction bits |

## Verification
Two events can fall on the same edge: a reset, and a new sample entering while earlier samples are still moving through the three sections. The bench provokes this by raising reset and `in_valid` in one cycle in the middle of a tone burst. It then requires that no strobe appears for the sample presented with reset or for the samples in flight, that the outputs read zero, and that the samples after reset match a reference model restarted from zero state. Every output is also compared bit-exactly against an integer model, for back-to-back and for gapped streams.

// File: rtl/iir_fix_pkg.sv
package iir_fix_pkg;
  localparam int IN_W   = 8;
  localparam int IN_F   = 7;
  localparam int OUT_W  = 9;
  localparam int OUT_F  = 7;
  localparam int COEF_W = 16;
  localparam int COEF_F = 14;
  localparam int SEC_W  = 20;
  localparam int SEC_F  = 15;
  localparam int NACC_W = 32;
  localparam int NACC_F = 24;
  localparam int DACC_W = 32;
  localparam int DACC_F = 25;

  localparam int PROD_W   = SEC_W + COEF_W + 1;
  localparam int PROD_F   = SEC_F + COEF_F;
  localparam int NUM_SH   = PROD_F - NACC_F;
  localparam int DEN_SH   = PROD_F - DACC_F;
  localparam int ALIGN_SH = DACC_F - NACC_F;
  localparam int SEC_SH   = DACC_F - SEC_F;
  localparam int OUT_SH   = SEC_F - OUT_F;
  localparam int IN_SH    = SEC_F - IN_F;

  typedef logic signed [IN_W-1:0]   in_t;
  typedef logic signed [OUT_W-1:0]  out_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [SEC_W-1:0]  sec_t;
  typedef logic signed [NACC_W-1:0] nacc_t;
  typedef logic signed [DACC_W-1:0] dacc_t;
  typedef logic signed [PROD_W-1:0] prod_t;

  // full-precision product, one guard bit above the exact width
  function automatic prod_t mul_full(input sec_t x, input coef_t c);
    return prod_t'(x) * prod_t'(c);
  endfunction

  // round to nearest, ties toward +inf, by an arithmetic right shift
  function automatic prod_t rnd_prod(input prod_t v, input int sh);
    prod_t h;
    h = '0;
    h[sh-1] = 1'b1;
    return (v + h) >>> sh;
  endfunction

  function automatic sec_t scale_q(input sec_t x, input coef_t s);
    return sec_t'(rnd_prod(mul_full(x, s), COEF_F));
  endfunction

  function automatic nacc_t num_term(input sec_t x, input coef_t c);
    return nacc_t'(rnd_prod(mul_full(x, c), NUM_SH));
  endfunction

  function automatic dacc_t den_term(input sec_t y, input coef_t c);
    return dacc_t'(rnd_prod(mul_full(y, c), DEN_SH));
  endfunction

  function automatic sec_t dacc_to_sec(input dacc_t v);
    logic signed [DACC_W:0] e;
    logic signed [DACC_W:0] h;
    e = {v[DACC_W-1], v};
    h = '0;
    h[SEC_SH-1] = 1'b1;
    return sec_t'((e + h) >>> SEC_SH);
  endfunction

  function automatic out_t sec_to_out(input sec_t v);
    logic signed [SEC_W:0] e;
    logic signed [SEC_W:0] h;
    e = {v[SEC_W-1], v};
    h = '0;
    h[OUT_SH-1] = 1'b1;
    return out_t'((e + h) >>> OUT_SH);
  endfunction
endpackage

// File: rtl/iir_in_stage.sv
module iir_in_stage
  import iir_fix_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  in_t  din,
  output logic vld_o,
  output sec_t dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      dout  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) dout <= sec_t'(din) <<< IN_SH;
    end
  end
endmodule

// File: rtl/iir_dfi_section.sv
module iir_dfi_section
  import iir_fix_pkg::*;
#(
  parameter bit    SECOND = 1'b1,
  parameter coef_t C_B0   = '0,
  parameter coef_t C_B1   = '0,
  parameter coef_t C_B2   = '0,
  parameter coef_t C_A1   = '0,
  parameter coef_t C_A2   = '0,
  parameter coef_t C_SCL  = coef_t'(1 << COEF_F)
) (
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  sec_t d_i,
  output logic vld_o,
  output sec_t d_o
);
  sec_t  xs, x1, x2, y1, y2, y;
  nacc_t nacc;
  dacc_t dacc;

  always_comb begin
    xs   = scale_q(d_i, C_SCL);
    nacc = num_term(xs, C_B0) + num_term(x1, C_B1) + num_term(x2, C_B2);
    dacc = (dacc_t'(nacc) <<< ALIGN_SH) - den_term(y1, C_A1) - den_term(y2, C_A2);
    y    = dacc_to_sec(dacc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      x1    <= '0;
      y1    <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        x1 <= xs;
        y1 <= y;
      end
    end
  end

  generate
    if (SECOND) begin : g_second
      always_ff @(posedge clk) begin
        if (rst) begin
          x2 <= '0;
          y2 <= '0;
        end else if (vld_i) begin
          x2 <= x1;
          y2 <= y1;
        end
      end
    end else begin : g_first
      assign x2 = '0;
      assign y2 = '0;
    end
  endgenerate

  assign d_o = y1;
endmodule

// File: rtl/iir_out_stage.sv
module iir_out_stage
  import iir_fix_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  sec_t din,
  output logic vld_o,
  output out_t dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      dout  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) dout <= sec_to_out(din);
    end
  end
endmodule

// File: rtl/iir_lp5_cascade.sv
module iir_lp5_cascade
  import iir_fix_pkg::*;
#(
  parameter int                       N_SEC   = 3,
  parameter logic [N_SEC-1:0]         SO_MASK = 3'b011,
  parameter logic [N_SEC*COEF_W-1:0]  P_B0    = {16'sd564, 16'sd20, 16'sd20},
  parameter logic [N_SEC*COEF_W-1:0]  P_B1    = {16'sd564, 16'sd40, 16'sd40},
  parameter logic [N_SEC*COEF_W-1:0]  P_B2    = {16'sd0, 16'sd20, 16'sd20},
  parameter logic [N_SEC*COEF_W-1:0]  P_A1    = {-16'sd15257, -16'sd31982, -16'sd30906},
  parameter logic [N_SEC*COEF_W-1:0]  P_A2    = {16'sd0, 16'sd15679, 16'sd14600},
  parameter logic [N_SEC*COEF_W-1:0]  P_SCL   = {N_SEC{16'sd16384}}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);
  // stage 0 is the input register, stage k+1 the output of section k
  logic [N_SEC:0]  stg_vld;
  sec_t [N_SEC:0]  stg_dat;

  iir_in_stage u_in (
    .clk   (clk),
    .rst   (rst),
    .vld_i (in_valid),
    .din   (in_sample),
    .vld_o (stg_vld[0]),
    .dout  (stg_dat[0])
  );

  for (genvar k = 0; k < N_SEC; k++) begin : g_sec
    iir_dfi_section #(
      .SECOND (SO_MASK[k]),
      .C_B0   (coef_t'(P_B0[k*COEF_W +: COEF_W])),
      .C_B1   (coef_t'(P_B1[k*COEF_W +: COEF_W])),
      .C_B2   (coef_t'(P_B2[k*COEF_W +: COEF_W])),
      .C_A1   (coef_t'(P_A1[k*COEF_W +: COEF_W])),
      .C_A2   (coef_t'(P_A2[k*COEF_W +: COEF_W])),
      .C_SCL  (coef_t'(P_SCL[k*COEF_W +: COEF_W]))
    ) u_sec (
      .clk   (clk),
      .rst   (rst),
      .vld_i (stg_vld[k]),
      .d_i   (stg_dat[k]),
      .vld_o (stg_vld[k+1]),
      .d_o   (stg_dat[k+1])
    );
  end

  iir_out_stage u_out (
    .clk   (clk),
    .rst   (rst),
    .vld_i (stg_vld[N_SEC]),
    .din   (stg_dat[N_SEC]),
    .vld_o (out_valid),
    .dout  (out_sample)
  );
endmodule

// File: rtl/iir_lp5_checker.sv
module iir_lp5_checker
  import iir_fix_pkg::*;
#(
  parameter int N_SEC = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N_SEC:0] stg_vld,
  input sec_t [N_SEC:0] stg_dat,
  input logic           out_valid,
  input out_t           out_sample
);
  // R5: an accepted sample enters the first register
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> stg_vld[0]);

  // R6: the input register holds while no sample arrives
  a_r6_in_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(stg_dat[0]));

  for (genvar k = 0; k < N_SEC; k++) begin : g_chk
    // R5: each section passes its strobe on after one edge
    a_r5_chain: assert property (@(posedge clk) disable iff (rst)
      stg_vld[k] |=> stg_vld[k+1]);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !stg_vld[k] |=> !stg_vld[k+1]);
    // R6: section state holds without a strobe
    a_r6_sec_hold: assert property (@(posedge clk) disable iff (rst)
      !stg_vld[k] |=> $stable(stg_dat[k+1]));
  end

  // R5: output strobe follows the last section
  a_r5_out_follow: assert property (@(posedge clk) disable iff (rst)
    stg_vld[N_SEC] |=> out_valid);
  a_r5_out_quiet: assert property (@(posedge clk) disable iff (rst)
    !stg_vld[N_SEC] |=> !out_valid);

  // R6: output value holds between strobes
  a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
    !stg_vld[N_SEC] |=> $stable(out_sample));

  // R7: reset clears strobes and output
  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sample == '0 && stg_vld == '0));
endmodule

bind iir_lp5_cascade iir_lp5_checker #(.N_SEC(N_SEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .stg_vld    (stg_vld),
  .stg_dat    (stg_dat),
  .out_valid  (out_valid),
  .out_sample (out_sample)
);

// File: tb/tb_iir_lp5_cascade.sv
module tb_iir_lp5_cascade;
  localparam int NS  = 3;
  localparam int LAT = NS + 1;
  localparam int CB0 [NS] = '{20, 20, 564};
  localparam int CB1 [NS] = '{40, 40, 564};
  localparam int CB2 [NS] = '{20, 20, 0};
  localparam int CA1 [NS] = '{-30906, -31982, -15257};
  localparam int CA2 [NS] = '{14600, 15679, 0};
  localparam int CSC [NS] = '{16384, 16384, 16384};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [7:0] in_sample = '0;
  logic out_valid;
  logic signed [8:0] out_sample;

  always #5 clk = ~clk;

  iir_lp5_cascade #(
    .P_B0  ({16'(CB0[2]), 16'(CB0[1]), 16'(CB0[0])}),
    .P_B1  ({16'(CB1[2]), 16'(CB1[1]), 16'(CB1[0])}),
    .P_B2  ({16'(CB2[2]), 16'(CB2[1]), 16'(CB2[0])}),
    .P_A1  ({16'(CA1[2]), 16'(CA1[1]), 16'(CA1[0])}),
    .P_A2  ({16'(CA2[2]), 16'(CA2[1]), 16'(CA2[0])}),
    .P_SCL ({16'(CSC[2]), 16'(CSC[1]), 16'(CSC[0])})
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  int last_out = 0;
  bit done = 1'b0;
  string tag = "R1 R2 R3 R4 tones";

  typedef struct { int due; int val; string tg; } exp_t;
  exp_t q[$];

  longint mx1 [NS];
  longint mx2 [NS];
  longint my1 [NS];
  longint my2 [NS];

  always @(posedge clk) edges <= edges + 1;

  function automatic longint wrapw(longint v, int w);
    longint m;
    m = longint'(1) << w;
    v = v % m;
    if (v < 0) v += m;
    if (v >= m / 2) v -= m;
    return v;
  endfunction

  function automatic longint rnd(longint v, int sh);
    longint d, t;
    d = longint'(1) << sh;
    t = v + d / 2;
    if (t >= 0) return t / d;
    return -((-t + d - 1) / d);
  endfunction

  function automatic void model_clear();
    for (int k = 0; k < NS; k++) begin
      mx1[k] = 0; mx2[k] = 0; my1[k] = 0; my2[k] = 0;
    end
  endfunction

  function automatic int model_step(int x8);
    longint x, xs, nacc, dacc, y;
    x = longint'(x8) * 256;
    for (int k = 0; k < NS; k++) begin
      xs   = wrapw(rnd(x * CSC[k], 14), 20);
      nacc = wrapw(wrapw(rnd(xs * CB0[k], 5), 32) + wrapw(rnd(mx1[k] * CB1[k], 5), 32)
                   + wrapw(rnd(mx2[k] * CB2[k], 5), 32), 32);
      dacc = wrapw(nacc * 2 - wrapw(rnd(my1[k] * CA1[k], 4), 32)
                   - wrapw(rnd(my2[k] * CA2[k], 4), 32), 32);
      y    = wrapw(rnd(dacc, 10), 20);
      mx2[k] = mx1[k]; mx1[k] = xs;
      my2[k] = my1[k]; my1[k] = y;
      x = y;
    end
    return int'(wrapw(rnd(x, 8), 9));
  endfunction

  // output monitor, samples at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      checks++;
      if (out_valid !== 1'b0 || out_sample !== 9'sd0) begin
        fails++;
        $display("FAIL R7 reset: actual valid=%b data=%0d expected valid=0 data=0",
                 out_valid, out_sample);
      end
      last_out = 0;
    end else if (out_valid) begin
      checks++;
      if (q.size() == 0 || q[0].due != edges) begin
        fails++;
        $display("FAIL R5 strobe at edge %0d: actual=unexpected expected due=%0d",
                 edges, (q.size() == 0) ? -1 : q[0].due);
      end else begin
        if (int'(out_sample) != q[0].val) begin
          fails++;
          $display("FAIL %s: actual=%0d expected=%0d", q[0].tg, out_sample, q[0].val);
        end
        void'(q.pop_front());
      end
      last_out = int'(out_sample);
    end else begin
      checks++;
      if (int'(out_sample) != last_out) begin
        fails++;
        $display("FAIL R6 hold: actual=%0d expected=%0d", out_sample, last_out);
      end
      if (q.size() != 0 && q[0].due == edges) begin
        checks++;
        fails++;
        $display("FAIL R5 missing strobe: actual=none expected due=%0d", q[0].due);
        void'(q.pop_front());
      end
    end
  end

  task automatic send(int v);
    exp_t e;
    @(negedge clk);
    #1;
    in_valid  = 1'b1;
    in_sample = 8'(v);
    e.due = edges + LAT + 1;
    e.val = model_step(v);
    e.tg  = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
      in_valid = 1'b0;
    end
  endtask

  function automatic int tone_q(int f, int k);
    real s;
    int v;
    s = $sin(2.0 * 3.14159265358979 * f * k / 44100.0) * 128.0;
    v = int'($floor(s + 0.5));
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    return v;
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    #1;
    rst = 1'b0;
    idle(2);

    // R1 R2 R3 R4: tones back to back
    tag = "R1 R2 R3 R4 tones";
    for (int f = 50; f <= 300; f += 50)
      for (int k = 0; k <= 44100 / f; k++) send(tone_q(f, k));
    idle(12);

    // R6: same kind of stream with idle gaps
    tag = "R6 gapped";
    for (int f = 200; f <= 300; f += 50)
      for (int k = 0; k <= 44100 / f; k++) begin
        send(tone_q(f, k));
        idle(int'($urandom_range(0, 3)));
      end
    idle(12);

    // R7: reset together with a new sample while samples are in flight
    tag = "R7 post-reset";
    for (int k = 0; k < 6; k++) send(tone_q(300, k));
    @(negedge clk);
    #1;
    rst = 1'b1;
    in_valid = 1'b1;
    in_sample = 8'sd99;
    q.delete();
    model_clear();
    idle(2);
    rst = 1'b0;
    idle(2);
    for (int k = 0; k < 40; k++) send(tone_q(150, k));
    idle(12);

    // R4: full-scale extremes
    tag = "R4 extremes";
    for (int k = 0; k < 40; k++) send((k % 2 == 0) ? 127 : -128);
    for (int k = 0; k < 300; k++) send(-128);
    idle(12);

    // R8: settled DC response
    tag = "R8 dc";
    for (int k = 0; k < 700; k++) send(64);
    idle(12);
    checks++;
    if (last_out < 61 || last_out > 67) begin
      fails++;
      $display("FAIL R8 dc level: actual=%0d expected=64 +/- 3", last_out);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule